// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Sequencer

This block sits between an internal request stream and an external asynchronous static RAM. The RAM holds 32K bytes and has active-low chip, output and write enables. Each accepted request turns into a single read or write cycle on the RAM pins. Every strobe is held for a whole number of system clock cycles. Those counts are worked out at elaboration from the clock period and the RAM's minimum timing values, all given in picoseconds. The shared data bus is split into three pins: a drive value, a drive enable and a sampled input, which the pad ring combines.

Requests use a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the sequencer is idle. A requester that sees `req_ready` low keeps `req_valid` and its fields steady and waits. The address, direction and write data are latched at acceptance. Completion is reported by a one-cycle `rsp_valid` pulse, which has no back-pressure. For reads, `rsp_rdata` carries the returned byte and holds it until the next read completes.

Between transactions the chip enable is released, so the RAM drops into its automatic power-down state. A write that directly follows a read gets an extra turnaround cycle, so the RAM's outputs are off the bus before the write begins.

Top module: `sram_ctl`

## Requirements
- R1: While reset is asserted and after it is released, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: `mem_we_n` is 0 only while `mem_ce_n` is 0 and `mem_oe_n` is 1. `mem_dq_oe` is 1 exactly in the cycles where `mem_we_n` is 0. `mem_addr` does not change while `mem_we_n` is low or at the edge where it rises.
- R3: Each write starts with one setup cycle in which `mem_ce_n` is 0, `mem_we_n` is 1 and the bus is not driven. `mem_we_n` then stays low for exactly WPL_CYC cycles. WPL_CYC is the largest of: ceil(pulse width), ceil(data setup), ceil(chip-enable-to-write-end) minus 1, ceil(address-to-write-end) minus 1, ceil(write cycle) minus 1, and 1. With the default parameters this is 2 cycles.
- R4: Each read holds `mem_ce_n` = 0, `mem_oe_n` = 0 and `mem_we_n` = 1 for exactly RD_CYC cycles. RD_CYC is the largest ceiling of the address, output-enable, chip-enable and read-cycle times, which is 3 cycles by default. `mem_dq_i` is sampled at the edge that ends the last of those cycles.
- R5: When a write follows a read, at least three sampled cycles with `mem_oe_n` high separate the last cycle with `mem_oe_n` low from the first cycle with `mem_we_n` low. These are the idle, turnaround and setup cycles.
- R6: `rsp_valid` pulses for exactly one cycle per accepted request. The pulse appears at the edge that ends the read or write strobe. `rsp_rdata` changes only with a read's pulse, so a write leaves it unchanged.
- R7: `req_ready` is high only while idle, and `mem_ce_n` is high in every cycle where `req_ready` is high. A request held with `req_ready` low is accepted exactly once.
- R8: Transactions complete in the order they are accepted. A read returns the byte most recently written to that 15-bit address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Last byte read, held |
| mem_addr | output | 15 | RAM address pins |
| mem_ce_n | output | 1 | RAM chip enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_dq_o | output | 8 | Value to drive onto the RAM data bus |
| mem_dq_oe | output | 1 | Drive enable for the RAM data bus |
| mem_dq_i | input | 8 | Value sampled from the RAM data bus |

## Verification
The assertions assume that every input is a known value once reset is released. They also assume a requester keeps `req_valid` and its fields steady until it sees `req_ready`, and that `mem_dq_i` matters only at the read capture edge. The stimulus changes request pins only at falling clock edges. It holds them until a falling edge shows `req_ready` high, then drops `valid` at the next falling edge, so each request meets exactly one accepting edge. A RAM model in the bench returns a junk byte until the read strobe has lasted RD_CYC cycles, and it commits a write only at the rising edge of `mem_we_n`. This makes short strobes or early capture visible in the data that comes back.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_TURN = 3'd1,
    ST_WSU  = 3'd2,
    ST_WPL  = 3'd3,
    ST_RD   = 3'd4
  } st_t;

  // Round a picosecond interval up to whole clock cycles.
  function automatic int unsigned ps_to_cyc(input int unsigned t_ps, input int unsigned clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Cycles remaining after the one setup cycle, saturating at zero.
  function automatic int unsigned less_one(input int unsigned a);
    return (a > 0) ? a - 1 : 0;
  endfunction

endpackage

// File: rtl/sram_ctl_cnt.sv
module sram_ctl_cnt #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           c <= '0;
    else if (load)        c <= load_val;
    else if (c != '0)     c <= c - W'(1);
  end

  assign zero = (c == '0);

  // R3/R4: the wait counter steps down by one each cycle until it reaches zero
  a_r3_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !zero) |=> (c == $past(c) - W'(1)));

endmodule

// File: rtl/sram_ctl_dp.sv
module sram_ctl_dp #(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] wdata_in,
  input  logic          cap,
  input  logic [DW-1:0] dq_in,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic [DW-1:0] rdata_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= addr_in;
      wdata_q <= wdata_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rdata_q <= '0;
    else if (cap) rdata_q <= dq_in;
  end

  // R2: the latched address and data move only when a request is taken
  a_r2_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ($stable(addr_q) && $stable(wdata_q)));

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int AW        = 15,
  parameter int DW        = 8,
  parameter int CLK_PS    = 4000,
  parameter int T_RC_PS   = 12000,
  parameter int T_AA_PS   = 12000,
  parameter int T_ACE_PS  = 12000,
  parameter int T_DOE_PS  = 5000,
  parameter int T_WC_PS   = 12000,
  parameter int T_SCE_PS  = 8000,
  parameter int T_AW_PS   = 8000,
  parameter int T_PWE_PS  = 8000,
  parameter int T_SD_PS   = 7000,
  parameter int TURN_CYC  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_i
);
  // Read strobe: every read limit counts from the same edge.
  localparam int unsigned RD_CYC = umax(1,
    umax(umax(ps_to_cyc(T_AA_PS, CLK_PS), ps_to_cyc(T_DOE_PS, CLK_PS)),
         umax(ps_to_cyc(T_ACE_PS, CLK_PS), ps_to_cyc(T_RC_PS, CLK_PS))));
  // Write pulse: limits measured from the setup edge lose one cycle.
  localparam int unsigned WR_FROM_SU = less_one(umax(ps_to_cyc(T_WC_PS, CLK_PS),
    umax(ps_to_cyc(T_SCE_PS, CLK_PS), ps_to_cyc(T_AW_PS, CLK_PS))));
  localparam int unsigned WPL_CYC = umax(umax(1, WR_FROM_SU),
    umax(ps_to_cyc(T_PWE_PS, CLK_PS), ps_to_cyc(T_SD_PS, CLK_PS)));
  localparam int unsigned TRN_CYC = umax(1, TURN_CYC);
  localparam int unsigned CNT_MAX = umax(RD_CYC, umax(WPL_CYC, TRN_CYC));
  localparam int CNT_W = $clog2(CNT_MAX + 1);

  st_t              st, nxt;
  logic             acc, cnt_zero, cnt_load, last_rd, cap;
  logic [CNT_W-1:0] cnt_val;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q;

  assign req_ready = (st == ST_IDLE);
  assign acc       = req_ready && req_valid;
  assign cap       = (st == ST_RD) && cnt_zero;

  always_comb begin
    nxt = st;
    case (st)
      ST_IDLE: if (req_valid) nxt = req_write ? (last_rd ? ST_TURN : ST_WSU) : ST_RD;
      ST_TURN: if (cnt_zero)  nxt = ST_WSU;
      ST_WSU:                 nxt = ST_WPL;
      ST_WPL:  if (cnt_zero)  nxt = ST_IDLE;
      ST_RD:   if (cnt_zero)  nxt = ST_IDLE;
      default:                nxt = ST_IDLE;
    endcase
  end

  assign cnt_load = (nxt != st);
  always_comb begin
    case (nxt)
      ST_RD:   cnt_val = CNT_W'(RD_CYC - 1);
      ST_WPL:  cnt_val = CNT_W'(WPL_CYC - 1);
      ST_TURN: cnt_val = CNT_W'(TRN_CYC - 1);
      default: cnt_val = '0;
    endcase
  end

  sram_ctl_cnt #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val), .zero(cnt_zero)
  );

  sram_ctl_dp #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rst_n(rst_n), .accept(acc), .addr_in(req_addr), .wdata_in(req_wdata),
    .cap(cap), .dq_in(mem_dq_i), .addr_q(addr_q), .wdata_q(wdata_q), .rdata_q(rsp_rdata)
  );

  // State, completion pulse and strobes are all flops, so the pins never glitch.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      last_rd   <= 1'b0;
      rsp_valid <= 1'b0;
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else begin
      st        <= nxt;
      rsp_valid <= ((st == ST_RD) || (st == ST_WPL)) && cnt_zero;
      if (cap)                           last_rd <= 1'b1;
      else if (st == ST_WPL && cnt_zero) last_rd <= 1'b0;
      mem_ce_n  <= (nxt == ST_IDLE);
      mem_oe_n  <= (nxt != ST_RD);
      mem_we_n  <= (nxt != ST_WPL);
      mem_dq_oe <= (nxt == ST_WPL);
    end
  end

  assign mem_addr = addr_q;
  assign mem_dq_o = wdata_q;

  // Strobe run-length trackers for the width checks below.
  logic [CNT_W:0] we_run, oe_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_run <= '0;
      oe_run <= '0;
    end else begin
      we_run <= mem_we_n ? '0 : we_run + 1'b1;
      oe_run <= mem_oe_n ? '0 : oe_run + 1'b1;
    end
  end

  a_r1_ready_in_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> req_ready);
  a_r2_we_window: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));
  a_r2_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!mem_we_n) |-> $stable(mem_addr));
  a_r3_we_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_run == (CNT_W+1)'(WPL_CYC)));
  a_r3_setup_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> ($past(!mem_ce_n) && $past(!mem_dq_oe)));
  a_r4_oe_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (oe_run == (CNT_W+1)'(RD_CYC)));
  a_r5_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> ($past(mem_oe_n) && $past(mem_oe_n, 2) && $past(mem_oe_n, 3)));
  a_r6_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r6_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> $stable(rsp_rdata));
  a_r7_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_ce_n);

endmodule

// File: tb/sram_ctl_test.sv
`timescale 1ns/1ps
module sram_ctl_test;
  // Expected strobe lengths at a 4 ns clock, worked out from the timing values:
  // read = max(ceil(12/4), ceil(5/4)) = 3; write pulse = max(ceil(8/4), ceil(7/4), ceil(12/4)-1) = 2.
  localparam int EXP_RD = 3;
  localparam int EXP_WE = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [14:0] mem_addr;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_o;
  logic [7:0]  mem_dq_i = 8'hEE;

  always #2 clk = ~clk;

  sram_ctl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  int n_chk = 0, n_bad = 0, n_issued = 0, n_acked = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // RAM model and reference memory, kept apart.
  logic [7:0] ram   [logic [14:0]];
  logic [7:0] shadow[logic [14:0]];
  logic [8:0] expq[$];
  logic [7:0] last_read = 8'h00;

  function automatic logic [7:0] ram_rd(input logic [14:0] a);
    return ram.exists(a) ? ram[a] : 8'h00;
  endfunction
  function automatic logic [7:0] ref_rd(input logic [14:0] a);
    return shadow.exists(a) ? shadow[a] : 8'h00;
  endfunction

  int rd_age = 0;
  always @(posedge clk)
    rd_age <= (!mem_ce_n && !mem_oe_n && mem_we_n) ? rd_age + 1 : 0;

  // Pin monitor, sampled at the falling edge.
  logic p_we = 1, p_oe = 1, p_ce = 1, p_oe_d = 0, p_rsp = 0;
  int wl = 0, ol = 0, since_oe = 100;
  logic [14:0] w_addr = '0;
  bit pend = 0;
  logic [14:0] pend_a;
  logic [7:0]  pend_d;

  always @(negedge clk) if (rst_n) begin
    if (req_ready) chk(mem_ce_n == 1'b1, "R7 idle deselect", mem_ce_n, 1);
    if (!mem_we_n) begin
      chk(!mem_ce_n && mem_oe_n && mem_dq_oe, "R2 write window", {mem_ce_n, mem_oe_n, mem_dq_oe}, 3'b011);
      if (p_we) begin
        chk(!p_ce && !p_oe_d, "R3 setup cycle", {p_ce, p_oe_d}, 0);
        chk(since_oe >= 3, "R5 turnaround", since_oe, 3);
        w_addr = mem_addr;
        wl = 1;
      end else begin
        chk(mem_addr == w_addr, "R2 address steady", mem_addr, w_addr);
        wl++;
      end
      pend = 1; pend_a = mem_addr; pend_d = mem_dq_o;
    end else begin
      if (mem_dq_oe) chk(0, "R2 bus released", mem_dq_oe, 0);
      if (!p_we) chk(wl == EXP_WE, "R3 write pulse", wl, EXP_WE);
      if (pend) begin ram[pend_a] = pend_d; pend = 0; end
    end
    if (!mem_oe_n) begin
      ol++;
      since_oe = 0;
    end else begin
      if (!p_oe) chk(ol == EXP_RD, "R4 read strobe", ol, EXP_RD);
      ol = 0;
      since_oe++;
    end
    if (rsp_valid && p_rsp) chk(0, "R6 single pulse", 2, 1);
    mem_dq_i = (!mem_ce_n && !mem_oe_n && mem_we_n && rd_age >= EXP_RD - 1) ? ram_rd(mem_addr) : 8'hEE;
    p_we = mem_we_n; p_oe = mem_oe_n; p_ce = mem_ce_n; p_oe_d = mem_dq_oe; p_rsp = rsp_valid;
  end

  // Response collector.
  always @(negedge clk) if (rst_n && rsp_valid) begin
    n_acked++;
    if (expq.size() == 0) chk(0, "R6 unexpected ack", 1, 0);
    else begin
      logic [8:0] e;
      e = expq.pop_front();
      if (e[8]) begin
        chk(rsp_rdata == e[7:0], "R8 read data", rsp_rdata, e[7:0]);
        last_read = rsp_rdata;
      end else
        chk(rsp_rdata == last_read, "R6 rdata kept after write", rsp_rdata, last_read);
    end
  end

  task automatic issue(input bit w, input logic [14:0] a, input logic [7:0] d);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    n_issued++;
    if (w) begin shadow[a] = d; expq.push_back({1'b0, d}); end
    else expq.push_back({1'b1, ref_rd(a)});
  endtask

  task automatic finish_all();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired (R6 no completion) actual=%0d expected=%0d", n_acked, n_issued);
    finish_all();
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_valid,
        "R1 in reset", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rsp_valid}, 5'b11100);
    rst_n = 1;
    @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_valid && req_ready,
        "R1 after reset", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rsp_valid, req_ready}, 6'b111001);
    // Directed corners: address extremes, write then read, read then write at once.
    issue(1, 15'h0000, 8'hA5);
    issue(1, 15'h7FFF, 8'h5A);
    issue(0, 15'h7FFF, 8'h00);
    issue(1, 15'h7FFF, 8'hC3);
    issue(0, 15'h0000, 8'h00);
    issue(0, 15'h7FFF, 8'h00);
    issue(0, 15'h1234, 8'h00);
    // Random mix; back-to-back calls exercise back-pressure (R7).
    for (int i = 0; i < 400; i++) begin
      logic [14:0] a;
      a = ($urandom % 3 == 0) ? 15'($urandom) : 15'($urandom % 16);
      issue(1'($urandom % 2), a, 8'($urandom));
      if ($urandom % 4 == 0) repeat ($urandom % 3) @(negedge clk);
    end
    repeat (20) @(negedge clk);
    chk(n_acked == n_issued, "R7 each request accepted once", n_acked, n_issued);
    chk(expq.size() == 0, "R8 all completed", expq.size(), 0);
    finish_all();
  end

endmodule